// File: doc/BRIEF.md
# Committed-Load Value Signature Unit

This block keeps one 64-bit CRC signature for each hardware thread. The signature is built from the data values returned by load instructions as they commit at the head of the reorder buffer. Only loads that actually retire feed it. Squashed and wrong-path loads never reach the commit port, and stores or other instructions carry no load flag, so neither can disturb a signature. Up to two commits per cycle are accepted, and they are folded in program order, lane 0 before lane 1.

A test harness runs a program twice under the same synchronization order and compares the final signatures. If the two differ, a data race definitely took place. If they agree, a race is unlikely but still possible. A registered compare port checks a thread's signature against a reference from an earlier run.

The signature is architectural per-thread state. The operating system reads it through a combinational save port and writes it back through a restore port, so it follows a thread across context switches and migrations. A clear input starts a new run.

Top module: `load_sig_accum`

## Requirements
- R1: After a cycle with `rst_n` low, every thread's signature reads zero on the save port and `cmp_valid_o` is low.
- R2: A load folds its 64-bit operand D into signature S as follows: X = S xor D, then 64 steps, each shifting X left by one bit and, when the bit shifted out was 1, XOR-ing the polynomial 64'h42F0E1EBA9EA3693 into X. Starting from zero, D = 1 therefore yields 64'h42F0E1EBA9EA3693. The new value is visible on the save port after the clock edge that samples the commit.
- R3: A lane changes a signature only when both its valid and its is-load bits are set. A store, a non-memory instruction or an invalid lane leaves every signature unchanged.
- R4: A lane updates only the signature of the thread named by its thread id. Other threads keep their values.
- R5: Two loads in the same cycle are folded lane 0 first, then lane 1, whether they target the same thread or different threads.
- R6: The lane size code selects the width: 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = 64 bits. The operand is zero-extended to 64 bits before hashing, so data bits above the selected width have no effect.
- R7: A clear sets the selected thread's signature to zero on the next cycle. It takes priority over a same-cycle restore and any same-cycle commits to that thread.
- R8: A restore loads the supplied value into the selected thread's signature on the next cycle. Same-cycle commits to that thread are folded onto the restored value, not onto the old one.
- R9: The save port shows, without delay, the current signature of the thread named by `save_tid_i`.
- R10: One cycle after a compare request, `cmp_valid_o` is high and `cmp_mismatch_o` is high exactly when the signature held in the request cycle differs from the reference. In a cycle after no request, both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmt_valid_i | input | NUM_LANES | Commit lane carries a retiring instruction |
| cmt_is_load_i | input | NUM_LANES | Retiring instruction is a load |
| cmt_size_i | input | 2*NUM_LANES | Load size code per lane |
| cmt_tid_i | input | TID_W*NUM_LANES | Thread id per lane |
| cmt_data_i | input | 64*NUM_LANES | Load data per lane |
| clr_valid_i | input | 1 | Clear request |
| clr_tid_i | input | TID_W | Thread to clear |
| rstr_valid_i | input | 1 | Restore request |
| rstr_tid_i | input | TID_W | Thread to restore |
| rstr_sig_i | input | 64 | Value to restore |
| save_tid_i | input | TID_W | Thread whose signature is read out |
| save_sig_o | output | 64 | Current signature of the selected thread |
| cmp_req_i | input | 1 | Compare request |
| cmp_tid_i | input | TID_W | Thread to compare |
| cmp_ref_i | input | 64 | Reference signature |
| cmp_valid_o | output | 1 | Compare result valid |
| cmp_mismatch_o | output | 1 | Signature differed from the reference |

## Verification
Every cycle, the assertions check that a signature holds its value when nothing targets its thread. They also check that a clear always yields zero, that a restore with no competing commit lands exactly, and that the compare result follows its request by one cycle. Only the bench scenarios can show that the hash matches the polynomial and that lane order is respected. The same goes for zero-extension of narrow loads, isolation between threads, and the ordering corner cases: restore plus commit, clear against both, and a compare that sees the value from before a same-cycle commit.

// File: rtl/lsig_pkg.sv
// Shared types and the parallel CRC-64 fold used by the signature unit.
// Assumes the data word and the CRC state have the same width (64 bits).
package lsig_pkg;

    localparam int SIG_W = 64;

    typedef logic [SIG_W-1:0] sig_t;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } ld_size_e;

    // Folds one full data word into the state, MSB first, non-reflected.
    function automatic sig_t crc_fold(sig_t state, sig_t data, sig_t poly);
        sig_t c;
        logic fb;
        c = state;
        for (int i = SIG_W - 1; i >= 0; i--) begin
            fb = c[SIG_W-1] ^ data[i];
            c  = {c[SIG_W-2:0], 1'b0};
            if (fb) c = c ^ poly;
        end
        return c;
    endfunction

endpackage

// File: rtl/sig_zext.sv
// Zero-extends a load operand according to its size code.
// Assumes the upper bits of a narrow load may hold arbitrary values.
module sig_zext
    import lsig_pkg::*;
(
    input  logic [1:0] size_i,
    input  sig_t       raw_i,
    output sig_t       ext_o
);

    // Keep only the bytes that the size code covers.
    always_comb begin
        unique case (ld_size_e'(size_i))
            SZ_BYTE:  ext_o = {56'd0, raw_i[7:0]};
            SZ_HALF:  ext_o = {48'd0, raw_i[15:0]};
            SZ_WORD:  ext_o = {32'd0, raw_i[31:0]};
            default:  ext_o = raw_i;
        endcase
    end

    // R6: narrow operands never carry upper bits into the hash
    always_comb begin
        if (size_i == 2'd0) assert_byte_ext_R6: assert (ext_o[63:8] == 56'd0);
        if (size_i == 2'd1) assert_half_ext_R6: assert (ext_o[63:16] == 48'd0);
    end

endmodule

// File: rtl/sig_thread_slot.sv
// Holds one thread's signature register. In each cycle it picks the base
// (restored value or current value), chains the matching commit lanes in
// lane order, then applies clear priority.
// Assumes commit lanes are already in program order and operands are extended.
module sig_thread_slot
    import lsig_pkg::*;
#(
    parameter int   NUM_LANES = 2,
    parameter int   TID_W     = 2,
    parameter int   THREAD_ID = 0,
    parameter sig_t POLY      = 64'h42F0E1EBA9EA3693
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LANES-1:0]       lane_fire_i,
    input  logic [NUM_LANES*TID_W-1:0] lane_tid_i,
    input  sig_t                       lane_data_i [NUM_LANES],
    input  logic                       clr_valid_i,
    input  logic [TID_W-1:0]           clr_tid_i,
    input  logic                       rstr_valid_i,
    input  logic [TID_W-1:0]           rstr_tid_i,
    input  sig_t                       rstr_sig_i,
    output sig_t                       sig_o
);

    localparam logic [TID_W-1:0] MY_TID = TID_W'(THREAD_ID);

    logic [NUM_LANES-1:0] lane_hit;
    logic                 clr_hit;
    logic                 rstr_hit;
    sig_t                 chain [NUM_LANES+1];
    sig_t                 sig_d;
    sig_t                 sig_q;

    assign clr_hit  = clr_valid_i  && (clr_tid_i  == MY_TID);
    assign rstr_hit = rstr_valid_i && (rstr_tid_i == MY_TID);

    // Base of the chain: the restored value replaces the held one.
    assign chain[0] = rstr_hit ? rstr_sig_i : sig_q;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        // Lane l targets this thread when it fires with a matching id.
        assign lane_hit[l]  = lane_fire_i[l] &&
                              (lane_tid_i[l*TID_W +: TID_W] == MY_TID);
        // Fold lane l on top of the result of the lanes before it.
        assign chain[l+1]   = lane_hit[l] ? crc_fold(chain[l], lane_data_i[l], POLY)
                                          : chain[l];
    end

    // Clear wins over restore and commits.
    assign sig_d = clr_hit ? '0 : chain[NUM_LANES];

    // Signature register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= '0;
        else        sig_q <= sig_d;
    end

    assign sig_o = sig_q;

    // R7: a clear always leaves zero
    assert_clear_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hit |=> (sig_q == '0));

    // R3: untouched thread keeps its signature
    assert_idle_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_hit && !rstr_hit && (lane_hit == '0)) |=> $stable(sig_q));

    // R8: restore alone lands exactly
    assert_restore_exact_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rstr_hit && !clr_hit && (lane_hit == '0)) |=> (sig_q == $past(rstr_sig_i)));

endmodule

// File: rtl/sig_compare.sv
// Registered comparison of one thread's signature with a reference value.
// Assumes the signature sampled is the one held in the request cycle.
module sig_compare
    import lsig_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [TID_W-1:0] tid_i,
    input  sig_t             ref_i,
    input  sig_t             sigs_i [NUM_THREADS],
    output logic             valid_o,
    output logic             mismatch_o
);

    sig_t sel_sig;
    logic valid_q;
    logic mismatch_q;

    // Select the requested thread's signature.
    always_comb begin
        sel_sig = '0;
        for (int t = 0; t < NUM_THREADS; t++)
            if (tid_i == TID_W'(t)) sel_sig = sigs_i[t];
    end

    // Register the result one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q    <= 1'b0;
            mismatch_q <= 1'b0;
        end else begin
            valid_q    <= req_i;
            mismatch_q <= req_i && (sel_sig != ref_i);
        end
    end

    assign valid_o    = valid_q;
    assign mismatch_o = mismatch_q;

    // R10: result follows its request by one cycle
    assert_cmp_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o);

    // R10: no stale result without a request
    assert_cmp_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!valid_o && !mismatch_o));

endmodule

// File: rtl/load_sig_accum.sv
// Top of the committed-load signature unit: extends each commit lane's
// operand, keeps one signature slot per thread, and exposes save/restore,
// clear and compare access.
// Assumes commit lanes arrive in program order, lane 0 oldest.
module load_sig_accum
    import lsig_pkg::*;
#(
    parameter int          NUM_THREADS = 4,
    parameter int          NUM_LANES   = 2,
    parameter logic [63:0] POLY        = 64'h42F0E1EBA9EA3693,
    localparam int         TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_LANES-1:0]       cmt_valid_i,
    input  logic [NUM_LANES-1:0]       cmt_is_load_i,
    input  logic [NUM_LANES*2-1:0]     cmt_size_i,
    input  logic [NUM_LANES*TID_W-1:0] cmt_tid_i,
    input  logic [NUM_LANES*64-1:0]    cmt_data_i,
    input  logic                       clr_valid_i,
    input  logic [TID_W-1:0]           clr_tid_i,
    input  logic                       rstr_valid_i,
    input  logic [TID_W-1:0]           rstr_tid_i,
    input  logic [63:0]                rstr_sig_i,
    input  logic [TID_W-1:0]           save_tid_i,
    output logic [63:0]                save_sig_o,
    input  logic                       cmp_req_i,
    input  logic [TID_W-1:0]           cmp_tid_i,
    input  logic [63:0]                cmp_ref_i,
    output logic                       cmp_valid_o,
    output logic                       cmp_mismatch_o
);

    logic [NUM_LANES-1:0] lane_fire;
    sig_t                 lane_ext [NUM_LANES];
    sig_t                 sig_all  [NUM_THREADS];

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        // Only committed loads feed the hash.
        assign lane_fire[l] = cmt_valid_i[l] && cmt_is_load_i[l];

        sig_zext u_zext (
            .size_i (cmt_size_i[l*2 +: 2]),
            .raw_i  (cmt_data_i[l*64 +: 64]),
            .ext_o  (lane_ext[l])
        );
    end

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thread
        sig_thread_slot #(
            .NUM_LANES (NUM_LANES),
            .TID_W     (TID_W),
            .THREAD_ID (t),
            .POLY      (POLY)
        ) u_slot (
            .clk          (clk),
            .rst_n        (rst_n),
            .lane_fire_i  (lane_fire),
            .lane_tid_i   (cmt_tid_i),
            .lane_data_i  (lane_ext),
            .clr_valid_i  (clr_valid_i),
            .clr_tid_i    (clr_tid_i),
            .rstr_valid_i (rstr_valid_i),
            .rstr_tid_i   (rstr_tid_i),
            .rstr_sig_i   (rstr_sig_i),
            .sig_o        (sig_all[t])
        );
    end

    // Combinational read-out for the operating system's save path.
    always_comb begin
        save_sig_o = '0;
        for (int t = 0; t < NUM_THREADS; t++)
            if (save_tid_i == TID_W'(t)) save_sig_o = sig_all[t];
    end

    sig_compare #(
        .NUM_THREADS (NUM_THREADS),
        .TID_W       (TID_W)
    ) u_cmp (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_i      (cmp_req_i),
        .tid_i      (cmp_tid_i),
        .ref_i      (cmp_ref_i),
        .sigs_i     (sig_all),
        .valid_o    (cmp_valid_o),
        .mismatch_o (cmp_mismatch_o)
    );

    // R1: reset leaves no pending compare result
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !cmp_valid_o);

endmodule

// File: tb/load_sig_accum_tb_top.sv
`timescale 1ns/1ps
module load_sig_accum_tb_top;

    localparam int          NT   = 4;
    localparam int          NL   = 2;
    localparam logic [63:0] POLY = 64'h42F0E1EBA9EA3693;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NL-1:0] cmt_valid, cmt_is_load;
    logic [NL*2-1:0]  cmt_size;
    logic [NL*2-1:0]  cmt_tid;
    logic [NL*64-1:0] cmt_data;
    logic        clr_valid, rstr_valid, cmp_req;
    logic [1:0]  clr_tid, rstr_tid, save_tid, cmp_tid;
    logic [63:0] rstr_sig, cmp_ref, save_sig;
    logic        cmp_valid, cmp_mismatch;

    int checks = 0;
    int fails  = 0;
    logic [63:0] model [NT];

    always #2.5 clk = ~clk;

    load_sig_accum #(.NUM_THREADS(NT), .NUM_LANES(NL), .POLY(POLY)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmt_valid_i(cmt_valid), .cmt_is_load_i(cmt_is_load),
        .cmt_size_i(cmt_size), .cmt_tid_i(cmt_tid), .cmt_data_i(cmt_data),
        .clr_valid_i(clr_valid), .clr_tid_i(clr_tid),
        .rstr_valid_i(rstr_valid), .rstr_tid_i(rstr_tid), .rstr_sig_i(rstr_sig),
        .save_tid_i(save_tid), .save_sig_o(save_sig),
        .cmp_req_i(cmp_req), .cmp_tid_i(cmp_tid), .cmp_ref_i(cmp_ref),
        .cmp_valid_o(cmp_valid), .cmp_mismatch_o(cmp_mismatch)
    );

    typedef struct packed {
        logic        ld;
        logic [1:0]  sz;
        logic [1:0]  tid;
        logic [63:0] data;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd3, 2'd0, 64'h0123_4567_89AB_CDEF},
        '{1'b1, 2'd0, 2'd0, 64'hFFFF_FFFF_FFFF_FF5A},
        '{1'b0, 2'd3, 2'd0, 64'hDEAD_BEEF_0000_0001},
        '{1'b1, 2'd1, 2'd1, 64'hAAAA_BBBB_CCCC_1234},
        '{1'b1, 2'd2, 2'd2, 64'h7777_7777_8000_0001},
        '{1'b1, 2'd3, 2'd3, 64'h8000_0000_0000_0000},
        '{1'b0, 2'd0, 2'd3, 64'h0000_0000_0000_00FF},
        '{1'b1, 2'd0, 2'd1, 64'h0000_0000_0000_005A},
        '{1'b1, 2'd3, 2'd2, 64'hFFFF_FFFF_FFFF_FFFF},
        '{1'b1, 2'd2, 2'd0, 64'h1234_5678_9ABC_DEF0}
    };

    // Reference hash: XOR in the word, then shift it through the polynomial.
    function automatic logic [63:0] ref_step(input logic [63:0] s, input logic [63:0] d);
        logic [63:0] x;
        logic        m;
        x = s ^ d;
        for (int i = 0; i < 64; i++) begin
            m = x[63];
            x = x << 1;
            if (m) x = x ^ POLY;
        end
        return x;
    endfunction

    function automatic logic [63:0] ref_ext(input logic [1:0] sz, input logic [63:0] d);
        case (sz)
            2'd0:    return d & 64'hFF;
            2'd1:    return d & 64'hFFFF;
            2'd2:    return d & 64'hFFFF_FFFF;
            default: return d;
        endcase
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int t = 0; t < NT; t++) begin
            save_tid = 2'(t);
            #0.1;
            check(req, save_sig, model[t]);
        end
    endtask

    task automatic idle();
        cmt_valid = '0; cmt_is_load = '0; cmt_size = '0; cmt_tid = '0; cmt_data = '0;
        clr_valid = 0; clr_tid = 0; rstr_valid = 0; rstr_tid = 0; rstr_sig = '0;
        cmp_req = 0; cmp_tid = 0; cmp_ref = '0;
    endtask

    task automatic set_lane(input int l, input logic v, input logic ld,
                            input logic [1:0] sz, input logic [1:0] tid, input logic [63:0] d);
        cmt_valid[l]          = v;
        cmt_is_load[l]        = ld;
        cmt_size[l*2 +: 2]    = sz;
        cmt_tid[l*2 +: 2]     = tid;
        cmt_data[l*64 +: 64]  = d;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        idle();
        save_tid = 0;
        rst_n = 1'b0;
        for (int t = 0; t < NT; t++) model[t] = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        check_all("R1 reset signature");
        check("R1 reset cmp_valid", 64'(cmp_valid), 64'd0);
        rst_n = 1'b1;

        // Table walk: single loads and non-loads on lane 0 (R2, R3, R4, R6)
        for (int v = 0; v < NV; v++) begin
            set_lane(0, 1'b1, VECS[v].ld, VECS[v].sz, VECS[v].tid, VECS[v].data);
            if (VECS[v].ld)
                model[VECS[v].tid] = ref_step(model[VECS[v].tid], ref_ext(VECS[v].sz, VECS[v].data));
            tick();
            check_all("R2/R3/R4/R6 table vector");
        end

        // R2: known value, clear thread 2 then fold the word 1
        clr_valid = 1; clr_tid = 2; model[2] = '0;
        tick();
        set_lane(0, 1, 1, 2'd3, 2'd2, 64'd1);
        tick();
        save_tid = 2; #0.1;
        check("R2 known polynomial value", save_sig, 64'h42F0E1EBA9EA3693);
        model[2] = 64'h42F0E1EBA9EA3693;

        // R5: two loads on one thread, lane 0 first
        set_lane(0, 1, 1, 2'd3, 2'd1, 64'h1111_2222_3333_4444);
        set_lane(1, 1, 1, 2'd1, 2'd1, 64'hFFFF_0000_9999_ABCD);
        model[1] = ref_step(ref_step(model[1], 64'h1111_2222_3333_4444), 64'hABCD);
        tick();
        check_all("R5 same-thread lane order");

        // R4/R5: two loads on different threads in one cycle
        set_lane(0, 1, 1, 2'd3, 2'd2, 64'h5555_AAAA_5555_AAAA);
        set_lane(1, 1, 1, 2'd0, 2'd3, 64'h0000_0000_0000_00C3);
        model[2] = ref_step(model[2], 64'h5555_AAAA_5555_AAAA);
        model[3] = ref_step(model[3], 64'hC3);
        tick();
        check_all("R4 two threads same cycle");

        // R3: invalid lane with load flag, and valid non-load on lane 1
        set_lane(0, 0, 1, 2'd3, 2'd0, 64'hCAFE_F00D_CAFE_F00D);
        set_lane(1, 1, 0, 2'd3, 2'd0, 64'hCAFE_F00D_CAFE_F00D);
        tick();
        check_all("R3 non-load ignored");

        // R6: upper garbage of a byte load ignored (same byte, different high bits)
        set_lane(0, 1, 1, 2'd0, 2'd3, 64'h1234_0000_0000_0077);
        set_lane(1, 1, 1, 2'd0, 2'd2, 64'hFFFF_FFFF_FFFF_FF77);
        model[3] = ref_step(model[3], 64'h77);
        model[2] = ref_step(model[2], 64'h77);
        tick();
        check_all("R6 zero extension");

        // R8: restore with same-cycle commit folds onto the restored value
        rstr_valid = 1; rstr_tid = 0; rstr_sig = 64'hA5A5_5A5A_0F0F_F0F0;
        set_lane(0, 1, 1, 2'd2, 2'd0, 64'h0000_0000_DEAD_BEEF);
        model[0] = ref_step(64'hA5A5_5A5A_0F0F_F0F0, 64'hDEAD_BEEF);
        tick();
        check_all("R8 restore plus commit");

        // R8: restore alone
        rstr_valid = 1; rstr_tid = 3; rstr_sig = 64'h0BAD_C0DE_0BAD_C0DE;
        model[3] = 64'h0BAD_C0DE_0BAD_C0DE;
        tick();
        check_all("R8 restore alone");

        // R7: clear beats restore and commits on the same thread
        clr_valid = 1; clr_tid = 1;
        rstr_valid = 1; rstr_tid = 1; rstr_sig = 64'hFFFF_FFFF_0000_0000;
        set_lane(0, 1, 1, 2'd3, 2'd1, 64'h1);
        set_lane(1, 1, 1, 2'd3, 2'd1, 64'h2);
        model[1] = '0;
        tick();
        check_all("R7 clear priority");

        // R9: save port follows its select without a clock edge
        save_tid = 3; #0.1;
        check("R9 save read thread 3", save_sig, model[3]);
        save_tid = 0; #0.1;
        check("R9 save read thread 0", save_sig, model[0]);

        // R10: compare match
        cmp_req = 1; cmp_tid = 0; cmp_ref = model[0];
        tick();
        check("R10 match valid", 64'(cmp_valid), 64'd1);
        check("R10 match mismatch", 64'(cmp_mismatch), 64'd0);

        // R10: compare mismatch
        cmp_req = 1; cmp_tid = 2; cmp_ref = model[2] ^ 64'h1;
        tick();
        check("R10 mismatch valid", 64'(cmp_valid), 64'd1);
        check("R10 mismatch flag", 64'(cmp_mismatch), 64'd1);

        // R10: compare sees the value held before a same-cycle commit
        cmp_req = 1; cmp_tid = 3; cmp_ref = model[3];
        set_lane(0, 1, 1, 2'd3, 2'd3, 64'h4242_4242_4242_4242);
        model[3] = ref_step(model[3], 64'h4242_4242_4242_4242);
        tick();
        check("R10 pre-commit compare", 64'(cmp_mismatch), 64'd0);
        check_all("R10 commit during compare");

        // R10: no request, result outputs low
        tick();
        check("R10 idle valid", 64'(cmp_valid), 64'd0);
        check("R10 idle mismatch", 64'(cmp_mismatch), 64'd0);

        // R1: reset again clears all threads
        rst_n = 0;
        tick();
        for (int t = 0; t < NT; t++) model[t] = '0;
        check_all("R1 reset after activity");
        rst_n = 1;

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule